// File: doc/BRIEF.md
# Coalescing Store Buffer with Load Search

This block sits between a write-through data cache and the memory system. Every store the processor performs is posted here and accepted at once, so the processor keeps running while the store waits for the memory write port. A pending store waits in one of a small number of slots. The slots drain to memory strictly in the order they were allocated, through a valid/ready write channel.

A store whose word address matches a pending slot is folded into that slot. The byte enables are combined, and only the bytes the new store enables are overwritten. No slot is consumed. The one exception is the slot currently offered to memory (the oldest one). It is frozen, so a matching store opens a new slot behind it.

Loads probe every pending slot in parallel with a word address and a byte mask. When several slots hold the same address, the youngest one answers. The load gets a full hit with forwarded data when that slot covers every requested byte. It gets a partial indication when the address matches but some requested byte is absent, and it must then wait for the drain.

Top module: `store_merge_buf`

## Requirements
- R1: After reset the buffer is empty: `mem_valid`, `ld_hit` and `ld_partial` are 0, and `st_ready` is 1.
- R2: A store to an address with no mergeable slot takes a new slot. Slots appear on the memory port oldest first, each carrying the store's address, enables and data. Bytes whose enable is 0 read as zero.
- R3: A store to the address of a pending slot that is not the oldest merges into it. The enables are ORed and only the newly enabled bytes are replaced, with no extra memory write.
- R4: The oldest pending slot, which is the one presented on the memory port, never merges. A store to its address takes a new slot.
- R5: A load whose youngest matching slot enables every byte set in `ld_be` gives `ld_hit`=1 with that slot's data on `ld_data`, combinationally from the current buffer state.
- R6: A load whose youngest matching slot lacks a requested byte gives `ld_partial`=1 and `ld_hit`=0. The two outputs are never 1 together.
- R7: A load to an address held by no pending slot gives `ld_hit`=0 and `ld_partial`=0.
- R8: With all DEPTH slots (default 4) occupied, `st_ready` is 0 for a store that cannot merge and 1 for one that can. The occupancy never exceeds DEPTH.
- R9: While `mem_valid` is 1 and `mem_ready` is 0, the memory payload stays unchanged and `mem_valid` stays 1.
- R10: A store accepted in the same cycle as a memory write takes effect alongside the drain. Back-to-back stores with the memory always ready all reach memory in order.
- R11: When two slots hold the same address, a load is answered from the younger one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store offered |
| st_ready | output | 1 | Store can be taken (free slot or merge target) |
| st_addr | input | ADDR_W | Store word address |
| st_be | input | DATA_W/8 | Store byte enables |
| st_data | input | DATA_W | Store data |
| ld_addr | input | ADDR_W | Load word address |
| ld_be | input | DATA_W/8 | Bytes the load needs |
| ld_hit | output | 1 | All requested bytes are pending; data forwarded |
| ld_partial | output | 1 | Address pending but some requested byte missing |
| ld_data | output | DATA_W | Data of the youngest matching slot |
| mem_valid | output | 1 | Oldest slot offered to memory |
| mem_ready | input | 1 | Memory takes the offered write |
| mem_addr | output | ADDR_W | Write address |
| mem_be | output | DATA_W/8 | Write byte enables |
| mem_data | output | DATA_W | Write data |

## Verification
A store can be accepted in the same cycle that the oldest slot leaves for memory. That overlap moves the head and tail pointers together while the occupancy holds still. The bench provokes it by holding `mem_ready` high and posting stores on consecutive cycles. A scoreboard filled by the store driver then requires each memory write, in order, with the exact address, enables and data. Merges into a non-oldest slot made while the head waits are judged the same way, against hand-merged values.

// File: rtl/smb_pkg.sv
package smb_pkg;
   typedef enum logic [1:0] {
      LK_MISS    = 2'd0,
      LK_PARTIAL = 2'd1,
      LK_FULL    = 2'd2
   } lookup_kind_e;
endpackage

// File: rtl/smb_slot.sv
module smb_slot #(
   parameter int ADDR_W = 30,
   parameter int DATA_W = 32,
   localparam int BE_W  = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alloc_i,
   input  logic              merge_i,
   input  logic              free_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic [BE_W-1:0]   wr_be_i,
   input  logic [DATA_W-1:0] wr_data_i,
   output logic              valid_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic [BE_W-1:0]   be_o,
   output logic [DATA_W-1:0] data_o
);
   logic [DATA_W-1:0] wr_mask;
   logic [DATA_W-1:0] merged;

   always_comb begin
      for (int b = 0; b < BE_W; b++) begin
         wr_mask[b*8 +: 8] = {8{wr_be_i[b]}};
      end
      merged = (data_o & ~wr_mask) | (wr_data_i & wr_mask);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_o <= 1'b0;
         addr_o  <= '0;
         be_o    <= '0;
         data_o  <= '0;
      end else begin
         if (free_i) valid_o <= 1'b0;
         if (alloc_i) begin
            valid_o <= 1'b1;
            addr_o  <= wr_addr_i;
            be_o    <= wr_be_i;
            data_o  <= wr_data_i & wr_mask;
         end else if (merge_i) begin
            be_o    <= be_o | wr_be_i;
            data_o  <= merged;
         end
      end
   end

   // R2
   slot_reuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_i |-> !valid_o);
   // R3
   merge_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
      merge_i |-> (valid_o && !alloc_i));
endmodule

// File: rtl/smb_search.sv
module smb_search #(
   parameter int ADDR_W = 30,
   parameter int DEPTH  = 4,
   localparam int PTR_W = $clog2(DEPTH)
) (
   input  logic [DEPTH-1:0][ADDR_W-1:0] ent_addr_i,
   input  logic [DEPTH-1:0]             ent_en_i,
   input  logic [PTR_W-1:0]             oldest_i,
   input  logic [ADDR_W-1:0]            key_i,
   output logic                         found_o,
   output logic [PTR_W-1:0]             idx_o
);
   logic [PTR_W-1:0] slot;

   // Walk from oldest to youngest; the last match is the youngest one.
   always_comb begin
      found_o = 1'b0;
      idx_o   = '0;
      slot    = '0;
      for (int k = 0; k < DEPTH; k++) begin
         slot = oldest_i + PTR_W'(k);
         if (ent_en_i[slot] && (ent_addr_i[slot] == key_i)) begin
            found_o = 1'b1;
            idx_o   = slot;
         end
      end
   end
endmodule

// File: rtl/store_merge_buf.sv
module store_merge_buf
   import smb_pkg::*;
#(
   parameter int ADDR_W = 30,
   parameter int DATA_W = 32,
   parameter int DEPTH  = 4,
   localparam int BE_W  = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              st_valid,
   output logic              st_ready,
   input  logic [ADDR_W-1:0] st_addr,
   input  logic [BE_W-1:0]   st_be,
   input  logic [DATA_W-1:0] st_data,
   input  logic [ADDR_W-1:0] ld_addr,
   input  logic [BE_W-1:0]   ld_be,
   output logic              ld_hit,
   output logic              ld_partial,
   output logic [DATA_W-1:0] ld_data,
   output logic              mem_valid,
   input  logic              mem_ready,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [BE_W-1:0]   mem_be,
   output logic [DATA_W-1:0] mem_data
);
   localparam int PTR_W = $clog2(DEPTH);
   localparam int CNT_W = PTR_W + 1;

   generate
      if (DATA_W % 8 != 0 || DATA_W < 8) begin : g_bad_width
         $error("store_merge_buf: DATA_W must be a positive multiple of 8");
      end
      if (DEPTH < 2 || (1 << PTR_W) != DEPTH) begin : g_bad_depth
         $error("store_merge_buf: DEPTH must be a power of two, at least 2");
      end
   endgenerate

   logic [PTR_W-1:0] head_q, tail_q;
   logic [CNT_W-1:0] count_q;

   logic [DEPTH-1:0]             s_valid;
   logic [DEPTH-1:0][ADDR_W-1:0] s_addr;
   logic [DEPTH-1:0][BE_W-1:0]   s_be;
   logic [DEPTH-1:0][DATA_W-1:0] s_data;

   logic [DEPTH-1:0] head_onehot;
   logic [DEPTH-1:0] merge_cand;
   logic             mg_found, lk_found;
   logic [PTR_W-1:0] mg_idx, lk_idx;
   logic             full, st_fire, do_merge, do_alloc, pop;
   lookup_kind_e     lk_kind;

   assign head_onehot = DEPTH'(1) << head_q;
   assign merge_cand  = s_valid & ~head_onehot;
   assign full        = (count_q == CNT_W'(DEPTH));

   smb_search #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_merge_search (
      .ent_addr_i (s_addr),
      .ent_en_i   (merge_cand),
      .oldest_i   (head_q),
      .key_i      (st_addr),
      .found_o    (mg_found),
      .idx_o      (mg_idx)
   );

   smb_search #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_load_search (
      .ent_addr_i (s_addr),
      .ent_en_i   (s_valid),
      .oldest_i   (head_q),
      .key_i      (ld_addr),
      .found_o    (lk_found),
      .idx_o      (lk_idx)
   );

   assign st_ready = mg_found || !full;
   assign st_fire  = st_valid && st_ready;
   assign do_merge = st_fire && mg_found;
   assign do_alloc = st_fire && !mg_found;

   assign mem_valid = s_valid[head_q];
   assign mem_addr  = s_addr[head_q];
   assign mem_be    = s_be[head_q];
   assign mem_data  = s_data[head_q];
   assign pop       = mem_valid && mem_ready;

   genvar gi;
   generate
      for (gi = 0; gi < DEPTH; gi++) begin : g_slot
         smb_slot #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .alloc_i   (do_alloc && (tail_q == PTR_W'(gi))),
            .merge_i   (do_merge && (mg_idx == PTR_W'(gi))),
            .free_i    (pop && (head_q == PTR_W'(gi))),
            .wr_addr_i (st_addr),
            .wr_be_i   (st_be),
            .wr_data_i (st_data),
            .valid_o   (s_valid[gi]),
            .addr_o    (s_addr[gi]),
            .be_o      (s_be[gi]),
            .data_o    (s_data[gi])
         );
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         head_q  <= '0;
         tail_q  <= '0;
         count_q <= '0;
      end else begin
         if (do_alloc) tail_q <= tail_q + PTR_W'(1);
         if (pop)      head_q <= head_q + PTR_W'(1);
         count_q <= count_q + CNT_W'(do_alloc) - CNT_W'(pop);
      end
   end

   always_comb begin
      if (!lk_found)                             lk_kind = LK_MISS;
      else if ((ld_be & ~s_be[lk_idx]) == '0)    lk_kind = LK_FULL;
      else                                       lk_kind = LK_PARTIAL;
   end

   assign ld_hit     = (lk_kind == LK_FULL);
   assign ld_partial = (lk_kind == LK_PARTIAL);
   assign ld_data    = s_data[lk_idx];

   // R9
   mem_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && !mem_ready) |=>
         (mem_valid && $stable(mem_addr) && $stable(mem_be) && $stable(mem_data)));
   // R8
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      count_q <= CNT_W'(DEPTH));
   // R6
   hit_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(ld_hit && ld_partial));
   // R10
   overlap_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (do_alloc && pop) |=> $stable(count_q));
endmodule

// File: tb/store_merge_buf_bench.sv
module store_merge_buf_bench;
   localparam int AW = 30;
   localparam int DW = 32;
   localparam int BW = 4;

   typedef struct packed {
      logic [AW-1:0] addr;
      logic [BW-1:0] be;
      logic [DW-1:0] data;
   } wr_item_t;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          st_valid, st_ready;
   logic [AW-1:0] st_addr;
   logic [BW-1:0] st_be;
   logic [DW-1:0] st_data;
   logic [AW-1:0] ld_addr;
   logic [BW-1:0] ld_be;
   logic          ld_hit, ld_partial;
   logic [DW-1:0] ld_data;
   logic          mem_valid, mem_ready;
   logic [AW-1:0] mem_addr;
   logic [BW-1:0] mem_be;
   logic [DW-1:0] mem_data;

   int checks = 0;
   int errors = 0;
   wr_item_t sb_q[$];

   always #4 clk = ~clk;

   store_merge_buf u_store_merge_buf (
      .clk(clk), .rst_n(rst_n),
      .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr),
      .st_be(st_be), .st_data(st_data),
      .ld_addr(ld_addr), .ld_be(ld_be), .ld_hit(ld_hit),
      .ld_partial(ld_partial), .ld_data(ld_data),
      .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
      .mem_be(mem_be), .mem_data(mem_data)
   );

   task automatic check(input string req, input logic [63:0] act,
                        input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic expect_wr(input logic [AW-1:0] a, input logic [BW-1:0] b,
                            input logic [DW-1:0] d);
      sb_q.push_back('{addr: a, be: b, data: d});
   endtask

   // Drives from posedge+1; returns at posedge+1 after acceptance.
   task automatic post(input logic [AW-1:0] a, input logic [BW-1:0] b,
                       input logic [DW-1:0] d);
      st_valid = 1'b1; st_addr = a; st_be = b; st_data = d;
      do @(negedge clk); while (!st_ready);
      @(posedge clk); #1;
      st_valid = 1'b0;
   endtask

   task automatic probe_load(input string req, input logic [AW-1:0] a,
                             input logic [BW-1:0] b, input logic hit,
                             input logic part, input logic [DW-1:0] d);
      ld_addr = a; ld_be = b;
      @(negedge clk);
      check(req, {62'd0, ld_hit, ld_partial}, {62'd0, hit, part});
      if (hit) check(req, 64'(ld_data), 64'(d));
      @(posedge clk); #1;
   endtask

   // Scoreboard monitor: a transfer seen mid-cycle completes at the next edge.
   always @(negedge clk) begin
      if (rst_n && mem_valid && mem_ready) begin
         if (sb_q.size() == 0) begin
            checks++; errors++;
            $display("FAIL R2 unexpected write actual=%h expected=none", mem_addr);
         end else begin
            wr_item_t e;
            e = sb_q.pop_front();
            check("R2 R3 drain", {2'b0, mem_addr, mem_be, mem_data},
                  {2'b0, e.addr, e.be, e.data});
         end
      end
   end

   initial begin
      #400000;
      checks++; errors++;
      $display("FAIL R10 watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      rst_n = 1'b0; st_valid = 1'b0; st_addr = '0; st_be = '0; st_data = '0;
      ld_addr = '0; ld_be = '0; mem_ready = 1'b0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 mem_valid", 64'(mem_valid), 64'd0);
      check("R1 st_ready", 64'(st_ready), 64'd1);
      check("R1 ld_hit", 64'(ld_hit), 64'd0);
      check("R1 ld_partial", 64'(ld_partial), 64'd0);
      @(posedge clk); #1;

      // Fill while memory stalls (R2, R3, R4)
      post(30'd10, 4'b0001, 32'h000000AA); expect_wr(30'd10, 4'b0001, 32'h000000AA);
      post(30'd10, 4'b0010, 32'h0000BB00);  // R4 head frozen: new slot
      post(30'd20, 4'b0011, 32'h00001122);
      post(30'd20, 4'b1100, 32'h33440000);  // R3 merge
      post(30'd10, 4'b0100, 32'h00CC0000);  // R3 merge into younger slot of 10
      expect_wr(30'd10, 4'b0110, 32'h00CCBB00);

      // R11 youngest wins, R5 full hit, R6 partial, R7 miss
      probe_load("R11", 30'd10, 4'b0110, 1'b1, 1'b0, 32'h00CCBB00);
      probe_load("R6", 30'd10, 4'b0001, 1'b0, 1'b1, 32'h0);
      probe_load("R5", 30'd20, 4'b1111, 1'b1, 1'b0, 32'h33441122);
      probe_load("R7", 30'd30, 4'b1111, 1'b0, 1'b0, 32'h0);

      post(30'd40, 4'b1111, 32'hDEADBEEF);  // now full
      // R8 full: non-mergeable store refused, mergeable accepted
      st_addr = 30'd50;
      @(negedge clk); check("R8 full no merge", 64'(st_ready), 64'd0);
      st_addr = 30'd20;
      @(negedge clk); check("R8 full merge", 64'(st_ready), 64'd1);
      @(posedge clk); #1;
      post(30'd20, 4'b1000, 32'h77000000);
      expect_wr(30'd20, 4'b1111, 32'h77441122);
      expect_wr(30'd40, 4'b1111, 32'hDEADBEEF);

      // R9 payload held while stalled
      repeat (3) @(negedge clk);
      check("R9 valid", 64'(mem_valid), 64'd1);
      check("R9 payload", {2'b0, mem_addr, mem_be, mem_data},
            {2'b0, 30'd10, 4'b0001, 32'h000000AA});
      @(posedge clk); #1;

      mem_ready = 1'b1;
      for (int i = 0; i < 20 && sb_q.size() != 0; i++) @(negedge clk);
      @(posedge clk); #1;
      @(negedge clk);
      check("R2 drained", 64'(mem_valid), 64'd0);
      @(posedge clk); #1;

      // R10 back-to-back stores overlapping drains
      for (int i = 0; i < 6; i++) begin
         expect_wr(30'(100 + i), 4'b1111, 32'hA5000000 + 32'(i));
         post(30'(100 + i), 4'b1111, 32'hA5000000 + 32'(i));
      end
      for (int i = 0; i < 20 && sb_q.size() != 0; i++) @(negedge clk);
      @(posedge clk); #1;
      @(negedge clk);
      check("R10 all drained", 64'(sb_q.size()), 64'd0);
      check("R10 empty", 64'(mem_valid), 64'd0);
      check("R10 ready", 64'(st_ready), 64'd1);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule